// File: doc/BRIEF.md
# Cursor Control Register Set with Shape Lock

This block holds the registers that control a display's hardware cursor: the base address of the cursor image, the on-screen position, the hot-spot offset inside the image, and two 24-bit colours. Software reaches them over a simple 32-bit write/read port with a word address. Writes take effect at the clock edge. Reads are combinational on the address.

The cursor image only has to be re-fetched when something that affects its appearance has changed. The block reports this with a one-cycle `shape_upd` pulse. To let software reprogram several registers without the drawing logic seeing a half-updated cursor, bit 31 of the base register acts as a lock. Software can set the lock and clear it through the position and hot-spot registers as well as through the base register. While the lock is held, no shape pulse is produced. Clearing a held lock through position or hot-spot fires a pulse, so the drawing logic picks up everything written in the meantime.

A separate `pos_valid` pulse tells the display that the cursor moved. It fires for position writes made while the cursor is enabled and the lock is not being requested.

Top module: `cursor_regs`

## Requirements
- R1: After reset, every register reads zero, the lock is clear, and `shape_upd` and `pos_valid` are low.
- R2: A write to word 0 (base) stores `wdata & 0x87FFFFF0`, and bit 31 of the stored value is the lock. `shape_upd` is high in the cycle after the write only when the stored value changed and the new lock bit is clear. `cur_base` carries stored bits 26:4.
- R3: A write to word 1 (position) stores `wdata & 0x3FFF0FFF`. `cur_x` is bits 29:16 and `cur_y` is bits 11:0.
- R4: A write to word 2 (hot-spot) stores `wdata & 0x003F003F`. `hot_x` is bits 21:16 and `hot_y` is bits 5:0.
- R5: A position or hot-spot write with bit 31 set sets the lock. With bit 31 clear, the write clears the lock, and if the lock was held it produces a `shape_upd` pulse in the next cycle.
- R6: Reads of words 1 and 2 return the stored value with the current lock in bit 31. A read of word 0 returns the stored base including the lock.
- R7: A write to word 3 (colour 0) keeps bits 23:0 and pulses `shape_upd` only if the value changed. Reads of word 3 return the value zero-extended.
- R8: A write to word 4 (colour 1) keeps bits 23:0 and pulses `shape_upd` on every write, even with an unchanged value. Reads of word 4 return the value zero-extended.
- R9: `shape_upd` never pulses for a write that leaves the lock set.
- R10: `pos_valid` is high in the cycle after a position write made with `cursor_en` high and `wdata[31]` clear, and is low otherwise.
- R11: Words 5 to 7 read as zero, and writes to them change no register and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| cursor_en | input | 1 | Cursor enabled (qualifies `pos_valid`) |
| rdata | output | 32 | Read data for `addr` |
| cur_base | output | 23 | Image base address, bits 26:4 |
| cur_lock | output | 1 | Shape lock |
| cur_x | output | 14 | Horizontal position |
| cur_y | output | 12 | Vertical position |
| hot_x | output | 6 | Hot-spot horizontal offset |
| hot_y | output | 6 | Hot-spot vertical offset |
| color0 | output | 24 | Colour 0 |
| color1 | output | 24 | Colour 1 |
| shape_upd | output | 1 | One-cycle redefine-shape pulse |
| pos_valid | output | 1 | One-cycle cursor-moved pulse |

## Verification
The hardest cases to reach are the strobe decisions that depend on history:
- a base write that rewrites the same value;
- a colour-0 write of the current colour;
- colour writes while the lock is held;
- a release of a held lock through the hot-spot register rather than the position register.

Random stimulus sets bit 31 about a third of the time. In a quarter of the base and colour-0 writes it replays the value the bench model holds, so no-change writes occur together with changing lock states. Directed sequences then lock through one register, write colours, and release through the other.

// File: rtl/cursor_regs.sv
module cursor_regs #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          cursor_en,
  output logic [31:0]   rdata,
  output logic [22:0]   cur_base,
  output logic          cur_lock,
  output logic [13:0]   cur_x,
  output logic [11:0]   cur_y,
  output logic [5:0]    hot_x,
  output logic [5:0]    hot_y,
  output logic [23:0]   color0,
  output logic [23:0]   color1,
  output logic          shape_upd,
  output logic          pos_valid
);
  localparam logic [31:0] BASE_MASK = 32'h87FF_FFF0;
  localparam logic [31:0] POS_MASK  = 32'h3FFF_0FFF;
  localparam logic [31:0] HOT_MASK  = 32'h003F_003F;
  localparam logic [AW-1:0] A_BASE = AW'(0);
  localparam logic [AW-1:0] A_POS  = AW'(1);
  localparam logic [AW-1:0] A_HOT  = AW'(2);
  localparam logic [AW-1:0] A_CLR0 = AW'(3);
  localparam logic [AW-1:0] A_CLR1 = AW'(4);

  logic [31:0] base_q, pos_q, hot_q;
  logic [23:0] c0_q, c1_q;
  logic        upd_q, pv_q;

  logic sel_base, sel_pos, sel_hot, sel_c0, sel_c1;
  assign sel_base = wr_en && addr == A_BASE;
  assign sel_pos  = wr_en && addr == A_POS;
  assign sel_hot  = wr_en && addr == A_HOT;
  assign sel_c0   = wr_en && addr == A_CLR0;
  assign sel_c1   = wr_en && addr == A_CLR1;

  logic [31:0] base_new;
  logic        base_chg, c0_chg, lock_nxt, upd_nxt;
  assign base_new = wdata & BASE_MASK;
  assign base_chg = sel_base && base_new != base_q;
  assign c0_chg   = sel_c0 && wdata[23:0] != c0_q;

  always_comb begin
    lock_nxt = base_q[31];
    if (base_chg)
      lock_nxt = base_new[31];
    else if (sel_pos || sel_hot)
      lock_nxt = wdata[31];
  end

  assign upd_nxt = !lock_nxt &&
                   (base_chg || c0_chg || sel_c1 ||
                    ((sel_pos || sel_hot) && !wdata[31] && base_q[31]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
      hot_q  <= '0;
      c0_q   <= '0;
      c1_q   <= '0;
      upd_q  <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      if (base_chg) base_q[30:0] <= base_new[30:0];
      base_q[31] <= lock_nxt;
      if (sel_pos) pos_q <= wdata & POS_MASK;
      if (sel_hot) hot_q <= wdata & HOT_MASK;
      if (sel_c0)  c0_q  <= wdata[23:0];
      if (sel_c1)  c1_q  <= wdata[23:0];
      upd_q <= upd_nxt;
      pv_q  <= sel_pos && cursor_en && !wdata[31];
    end
  end

  always_comb begin
    case (addr)
      A_BASE:  rdata = base_q;
      A_POS:   rdata = {base_q[31], pos_q[30:0]};
      A_HOT:   rdata = {base_q[31], hot_q[30:0]};
      A_CLR0:  rdata = {8'h00, c0_q};
      A_CLR1:  rdata = {8'h00, c1_q};
      default: rdata = '0;
    endcase
  end

  assign cur_base  = base_q[26:4];
  assign cur_lock  = base_q[31];
  assign cur_x     = pos_q[29:16];
  assign cur_y     = pos_q[11:0];
  assign hot_x     = hot_q[21:16];
  assign hot_y     = hot_q[5:0];
  assign color0    = c0_q;
  assign color1    = c1_q;
  assign shape_upd = upd_q;
  assign pos_valid = pv_q;

  a_r9_no_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
    shape_upd |-> !cur_lock);
  a_r5_release_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_POS || addr == A_HOT) && !wdata[31] && cur_lock)
    |=> (shape_upd && !cur_lock));
  a_r5_set_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_POS || addr == A_HOT) && wdata[31])
    |=> (cur_lock && !shape_upd));
  a_r8_clr1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR1 && !cur_lock) |=> shape_upd);
  a_r2_same_base_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_BASE && (wdata & BASE_MASK) == {cur_lock, 4'h0, cur_base, 4'h0})
    |=> !shape_upd);
  a_r3_pos_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_POS) |=> (cur_x == $past(wdata[29:16]) && cur_y == $past(wdata[11:0])));
  a_r10_pos_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_POS && cursor_en && !wdata[31]) |=> pos_valid);
  a_r7_same_clr0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR0 && wdata[23:0] == color0) |=> !shape_upd);
endmodule

// File: tb/test_cursor_regs.sv
`timescale 1ns/100ps
module test_cursor_regs;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cursor_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [22:0] cur_base;
  logic cur_lock, shape_upd, pos_valid;
  logic [13:0] cur_x;
  logic [11:0] cur_y;
  logic [5:0]  hot_x, hot_y;
  logic [23:0] color0, color1;

  cursor_regs #(.AW(3)) i_cursor_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cursor_en(cursor_en), .rdata(rdata), .cur_base(cur_base), .cur_lock(cur_lock),
    .cur_x(cur_x), .cur_y(cur_y), .hot_x(hot_x), .hot_y(hot_y),
    .color0(color0), .color1(color1), .shape_upd(shape_upd), .pos_valid(pos_valid));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] m_base = 0, m_pos = 0, m_hot = 0;
  logic [23:0] m_c0 = 0, m_c1 = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_base;
      3'd1: return {m_base[31], m_pos[30:0]};
      3'd2: return {m_base[31], m_hot[30:0]};
      3'd3: return {8'h00, m_c0};
      3'd4: return {8'h00, m_c1};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      addr = 3'(a);
      #0.5;
      chk(a == 1 || a == 2 ? "R6" : (a > 4 ? "R11" : "R2_R7_R8"), rdata, m_read(3'(a)));
    end
    chk("R3", {6'h0, cur_x, cur_y}, {6'h0, m_pos[29:16], m_pos[11:0]});
    chk("R4", {20'h0, hot_x, hot_y}, {20'h0, m_hot[21:16], m_hot[5:0]});
    chk("R2", {8'h0, cur_lock, cur_base}, {8'h0, m_base[31], m_base[26:4]});
    chk("R7_R8", {color0, 8'h0} ^ {8'h0, color1}, {m_c0, 8'h0} ^ {8'h0, m_c1});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic en);
    logic upd, pv, was_lock;
    string tag;
    was_lock = m_base[31];
    upd = 1'b0;
    pv = 1'b0;
    tag = "R11";
    case (a)
      3'd0: begin
        tag = "R2";
        if ((d & 32'h87FF_FFF0) != m_base) begin
          m_base = d & 32'h87FF_FFF0;
          upd = !m_base[31];
        end
      end
      3'd1, 3'd2: begin
        tag = "R5";
        if (a == 3'd1) begin m_pos = d & 32'h3FFF_0FFF; pv = en && !d[31]; end
        else m_hot = d & 32'h003F_003F;
        m_base[31] = d[31];
        upd = !d[31] && was_lock;
      end
      3'd3: begin
        tag = "R7";
        upd = (d[23:0] != m_c0) && !was_lock;
        m_c0 = d[23:0];
      end
      3'd4: begin
        tag = "R8";
        upd = !was_lock;
        m_c1 = d[23:0];
      end
      default: ;
    endcase
    if (m_base[31]) tag = "R9";
    @(negedge clk);
    addr = a; wdata = d; cursor_en = en; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tag, {31'h0, shape_upd}, {31'h0, upd});
    chk("R10", {31'h0, pos_valid}, {31'h0, pv});
  endtask

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {30'h0, shape_upd, pos_valid}, 32'h0);
    chk("R1", {31'h0, cur_lock}, 32'h0);
    check_all();

    wr(3'd0, 32'hFFFF_FFFF, 1'b0);
    check_all();
    wr(3'd0, 32'h7FFF_FFFF, 1'b0);
    wr(3'd0, 32'h0123_4567, 1'b0);
    wr(3'd0, 32'h0123_4567, 1'b0);
    wr(3'd1, 32'hFFFF_FFFF, 1'b1);
    check_all();
    wr(3'd3, 32'h00AB_CDEF, 1'b1);
    wr(3'd4, 32'h0011_2233, 1'b1);
    wr(3'd2, 32'h7FFF_FFFF, 1'b1);
    check_all();
    wr(3'd3, 32'hFFAB_CDEF, 1'b1);
    wr(3'd4, 32'h0011_2233, 1'b1);
    wr(3'd4, 32'h0011_2233, 1'b1);
    wr(3'd1, 32'h1234_5678, 1'b1);
    wr(3'd1, 32'h1234_5678, 1'b0);
    wr(3'd2, 32'h8000_0000, 1'b0);
    wr(3'd2, 32'h8000_0000, 1'b0);
    wr(3'd1, 32'h0000_0001, 1'b0);
    wr(3'd5, 32'hFFFF_FFFF, 1'b1);
    wr(3'd7, 32'h0000_0000, 1'b1);
    check_all();

    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom % 8);
      d = $urandom;
      d[31] = ($urandom % 3) == 0;
      if (a == 3'd0 && ($urandom % 4) == 0) d = m_base | ($urandom & 32'h7800_000F);
      if (a == 3'd3 && ($urandom % 4) == 0) d = {$urandom % 256, m_c0};
      wr(a, d, 1'($urandom));
      if (i % 20 == 0) check_all();
    end
    check_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule